// File: doc/BRIEF.md
# First-Match Masked Rule Classifier

This block decides what happens to a packet by checking its header fields against an ordered table of rules. Upstream logic parses the first 128 bytes of each frame. It delivers one flat key per frame holding the two MAC addresses, the IPv4 source and destination, the L4 source and destination ports, the ethertype, the IP protocol number and the VLAN ID. Each rule stores a value and a bit mask covering that whole key, plus a valid bit, an action and a target port. The lowest-numbered valid rule wins. A rule wins only if every field it cares about agrees with the key in all masked bit positions. The result carries that rule's index, action and port. If no rule matches, the result carries a miss indication with a default action and port.

Keys enter on a valid/ready stream and results leave on a second valid/ready stream. A key transfers on a clock edge where `key_valid` and `key_ready` are both high. A result transfers on an edge where `res_valid` and `res_ready` are both high. While the consumer holds `res_ready` low with a result pending, the whole pipeline freezes and `key_ready` drops. One lookup is accepted per cycle otherwise.

A separate write port installs, replaces or removes a complete rule in a single cycle. Traffic may keep flowing during updates. A lookup sees each rule either entirely old or entirely new.

Top module: `rcls_classifier`

## Requirements
- R1: After reset `res_valid` is low and every rule is invalid, so the first lookup returns a miss.
- R2: The key is packed, from MSB to LSB, as: destination MAC [227:180], source MAC [179:132], source IPv4 [131:100], destination IPv4 [99:68], source L4 port [67:52], destination L4 port [51:36], ethertype [35:20], IP protocol [19:12], VLAN ID [11:0]. A valid rule matches only if, in every field, each key bit whose mask bit is 1 equals the rule's value bit. A mismatch in any single field defeats the rule.
- R3: Key bits whose mask bit is 0 have no effect on whether that rule matches. A rule with an all-zero mask matches every key.
- R4: When several valid rules match, the result reports the one with the lowest index.
- R5: On a miss, `res_hit` is 0, `res_index` is 0, and `res_action`/`res_port` equal the parameters `DEF_ACTION`/`DEF_PORT`.
- R6: On a hit, `res_action` and `res_port` are the winning rule's stored values. Actions are encoded as 0 = drop, 1 = redirect, 2 = mirror, and code 3 never appears.
- R7: A key accepted at edge k produces its result one edge later (`res_valid` high after edge k+1) when no stall intervenes. Back-to-back keys yield one result per cycle, in order.
- R8: While `res_valid` is high and `res_ready` is low, the result outputs hold steady and `key_ready` is low.
- R9: A write with `wr_en` high stores the value, mask, action, port and valid bit (`wr_keep`) of rule `wr_index` in one edge. Clearing the valid bit removes the rule, and lookups after the write no longer match it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_valid | input | 1 | Header key offered |
| key_ready | output | 1 | Block can take a key this cycle |
| key_data | input | 228 | Packed header key (layout in R2) |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_hit | output | 1 | 1 when a rule matched |
| res_index | output | IDX_W | Index of the winning rule |
| res_action | output | 2 | 0 drop, 1 redirect, 2 mirror |
| res_port | output | PORT_W | Target port of the action |
| wr_en | input | 1 | Write one rule this cycle |
| wr_index | input | IDX_W | Rule slot to write |
| wr_keep | input | 1 | Valid bit to store (0 removes the rule) |
| wr_value | input | 228 | Compare value |
| wr_mask | input | 228 | Compare mask, 1 = bit is compared |
| wr_action | input | 2 | Action code |
| wr_port | input | PORT_W | Target port |

## Verification
Every cycle, the assertions watch the stream handshake. They confirm that a stalled result holds still and blocks new keys, and that an accepted key reaches the output once the pipeline advances. They also confirm that a miss always carries the default action and port, and that no undefined action code is ever emitted. Only the bench scenarios can show which rule wins. Those scenarios cover per-field masking, one-field mismatches defeating a rule, overlapping rules resolved by index, a catch-all rule, and removal or replacement of rules between lookups. The bench compares each of these against its own table model.

// File: rtl/rcls_pkg.sv
package rcls_pkg;

  typedef struct packed {
    logic [47:0] dmac;
    logic [47:0] smac;
    logic [31:0] sip;
    logic [31:0] dip;
    logic [15:0] sport;
    logic [15:0] dport;
    logic [15:0] etype;
    logic [7:0]  proto;
    logic [11:0] vid;
  } hdr_key_t;

  localparam int KEY_W = $bits(hdr_key_t);

  typedef enum logic [1:0] {
    ACT_DROP     = 2'd0,
    ACT_REDIRECT = 2'd1,
    ACT_MIRROR   = 2'd2
  } rule_act_e;

  // AND across fields of a masked per-field equality
  function automatic logic rule_hit(hdr_key_t k, hdr_key_t v, hdr_key_t m);
    logic [8:0] ok;
    ok[0] = ((k.dmac  ^ v.dmac)  & m.dmac)  == '0;
    ok[1] = ((k.smac  ^ v.smac)  & m.smac)  == '0;
    ok[2] = ((k.sip   ^ v.sip)   & m.sip)   == '0;
    ok[3] = ((k.dip   ^ v.dip)   & m.dip)   == '0;
    ok[4] = ((k.sport ^ v.sport) & m.sport) == '0;
    ok[5] = ((k.dport ^ v.dport) & m.dport) == '0;
    ok[6] = ((k.etype ^ v.etype) & m.etype) == '0;
    ok[7] = ((k.proto ^ v.proto) & m.proto) == '0;
    ok[8] = ((k.vid   ^ v.vid)   & m.vid)   == '0;
    return &ok;
  endfunction

endpackage

// File: rtl/rcls_rule_store.sv
module rcls_rule_store
  import rcls_pkg::*;
#(
  parameter int N_RULES = 16,
  parameter int PORT_W  = 3,
  parameter int IDX_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic              wr_keep,
  input  hdr_key_t          wr_value,
  input  hdr_key_t          wr_mask,
  input  logic [1:0]        wr_action,
  input  logic [PORT_W-1:0] wr_port,
  output logic [N_RULES-1:0] rule_valid,
  output hdr_key_t          rule_value  [N_RULES],
  output hdr_key_t          rule_mask   [N_RULES],
  output logic [1:0]        rule_action [N_RULES],
  output logic [PORT_W-1:0] rule_port   [N_RULES]
);

  for (genvar i = 0; i < N_RULES; i++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_index == IDX_W'(i));

    // whole rule lands on one edge: a lookup never sees a partial entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rule_valid[i] <= 1'b0;
      end else if (sel) begin
        rule_valid[i] <= wr_keep;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        rule_value[i]  <= wr_value;
        rule_mask[i]   <= wr_mask;
        rule_action[i] <= wr_action;
        rule_port[i]   <= wr_port;
      end
    end
  end

endmodule

// File: rtl/rcls_match_array.sv
module rcls_match_array
  import rcls_pkg::*;
#(
  parameter int N_RULES = 16
) (
  input  hdr_key_t           key,
  input  logic [N_RULES-1:0] rule_valid,
  input  hdr_key_t           rule_value [N_RULES],
  input  hdr_key_t           rule_mask  [N_RULES],
  output logic [N_RULES-1:0] hit_vec
);

  for (genvar i = 0; i < N_RULES; i++) begin : g_cmp
    assign hit_vec[i] = rule_valid[i] && rule_hit(key, rule_value[i], rule_mask[i]);
  end

endmodule

// File: rtl/rcls_prio_pick.sv
module rcls_prio_pick #(
  parameter int N_RULES = 16,
  parameter int IDX_W   = 4
) (
  input  logic [N_RULES-1:0] hit_vec,
  output logic               any_hit,
  output logic [IDX_W-1:0]   win_idx
);

  always_comb begin
    any_hit = |hit_vec;
    win_idx = '0;
    for (int i = N_RULES - 1; i >= 0; i--) begin
      if (hit_vec[i]) win_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/rcls_classifier.sv
module rcls_classifier
  import rcls_pkg::*;
#(
  parameter int                N_RULES    = 16,
  parameter int                PORT_W     = 3,
  parameter logic [1:0]        DEF_ACTION = 2'd0,
  parameter logic [PORT_W-1:0] DEF_PORT   = '0,
  localparam int               IDX_W      = (N_RULES > 1) ? $clog2(N_RULES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid,
  output logic              key_ready,
  input  logic [KEY_W-1:0]  key_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit,
  output logic [IDX_W-1:0]  res_index,
  output logic [1:0]        res_action,
  output logic [PORT_W-1:0] res_port,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic              wr_keep,
  input  logic [KEY_W-1:0]  wr_value,
  input  logic [KEY_W-1:0]  wr_mask,
  input  logic [1:0]        wr_action,
  input  logic [PORT_W-1:0] wr_port
);

  logic [N_RULES-1:0] rule_valid;
  hdr_key_t           rule_value  [N_RULES];
  hdr_key_t           rule_mask   [N_RULES];
  logic [1:0]         rule_action [N_RULES];
  logic [PORT_W-1:0]  rule_port   [N_RULES];

  logic               advance;
  logic               s1_valid;
  hdr_key_t           s1_key;
  logic [N_RULES-1:0] hit_vec;
  logic               any_hit;
  logic [IDX_W-1:0]   win_idx;

  rcls_rule_store #(.N_RULES(N_RULES), .PORT_W(PORT_W), .IDX_W(IDX_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_index   (wr_index),
    .wr_keep    (wr_keep),
    .wr_value   (hdr_key_t'(wr_value)),
    .wr_mask    (hdr_key_t'(wr_mask)),
    .wr_action  (wr_action),
    .wr_port    (wr_port),
    .rule_valid (rule_valid),
    .rule_value (rule_value),
    .rule_mask  (rule_mask),
    .rule_action(rule_action),
    .rule_port  (rule_port)
  );

  // global stall: the whole pipe moves only when the output slot frees
  assign advance   = !res_valid || res_ready;
  assign key_ready = advance;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_key   <= '0;
    end else if (advance) begin
      s1_valid <= key_valid;
      if (key_valid) s1_key <= hdr_key_t'(key_data);
    end
  end

  rcls_match_array #(.N_RULES(N_RULES)) u_match (
    .key       (s1_key),
    .rule_valid(rule_valid),
    .rule_value(rule_value),
    .rule_mask (rule_mask),
    .hit_vec   (hit_vec)
  );

  rcls_prio_pick #(.N_RULES(N_RULES), .IDX_W(IDX_W)) u_pick (
    .hit_vec(hit_vec),
    .any_hit(any_hit),
    .win_idx(win_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_index  <= '0;
      res_action <= DEF_ACTION;
      res_port   <= DEF_PORT;
    end else if (advance) begin
      res_valid <= s1_valid;
      if (s1_valid) begin
        res_hit    <= any_hit;
        res_index  <= any_hit ? win_idx : '0;
        res_action <= any_hit ? rule_action[win_idx] : DEF_ACTION;
        res_port   <= any_hit ? rule_port[win_idx]   : DEF_PORT;
      end
    end
  end

endmodule

// File: rtl/rcls_classifier_chk.sv
module rcls_classifier_chk #(
  parameter int                N_RULES    = 16,
  parameter int                PORT_W     = 3,
  parameter logic [1:0]        DEF_ACTION = 2'd0,
  parameter logic [PORT_W-1:0] DEF_PORT   = '0,
  localparam int               IDX_W      = (N_RULES > 1) ? $clog2(N_RULES) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              key_valid,
  input logic              key_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic              res_hit,
  input logic [IDX_W-1:0]  res_index,
  input logic [1:0]        res_action,
  input logic [PORT_W-1:0] res_port
);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_hit) && $stable(res_index)
                                && $stable(res_action) && $stable(res_port));

  p_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !key_ready);

  p_deliver_r7: assert property (@(posedge clk) disable iff (!rst_n)
    key_ready && $past(key_valid && key_ready) |=> res_valid);

  p_miss_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> res_action == DEF_ACTION && res_port == DEF_PORT
                              && res_index == '0);

  p_legal_action_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_hit |-> res_action != 2'd3);

endmodule

bind rcls_classifier rcls_classifier_chk #(
  .N_RULES(N_RULES), .PORT_W(PORT_W), .DEF_ACTION(DEF_ACTION), .DEF_PORT(DEF_PORT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_ready(key_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit),
  .res_index(res_index), .res_action(res_action), .res_port(res_port)
);

// File: tb/rcls_classifier_test.sv
module rcls_classifier_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int PW = 3;
  localparam int IW = 4;
  localparam int KW = rcls_pkg::KEY_W;
  localparam int RW = 1 + IW + 2 + PW;
  localparam logic [1:0]    DEFA = 2'd1;
  localparam logic [PW-1:0] DEFP = 3'd5;

  logic clk = 0, rst_n = 0;
  logic key_valid = 0, key_ready, res_valid, res_ready = 1, res_hit;
  logic [KW-1:0] key_data = '0;
  logic [IW-1:0] res_index;
  logic [1:0] res_action;
  logic [PW-1:0] res_port;
  logic wr_en = 0, wr_keep = 0;
  logic [IW-1:0] wr_index = '0;
  logic [KW-1:0] wr_value = '0, wr_mask = '0;
  logic [1:0] wr_action = '0;
  logic [PW-1:0] wr_port = '0;

  int checks = 0, errors = 0, cycles = 0;

  logic [KW-1:0] m_val [N];
  logic [KW-1:0] m_msk [N];
  logic          m_ok  [N];
  logic [1:0]    m_act [N];
  logic [PW-1:0] m_prt [N];

  logic [RW-1:0] expq [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rcls_classifier #(.N_RULES(N), .PORT_W(PW), .DEF_ACTION(DEFA), .DEF_PORT(DEFP)) uut (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_ready(key_ready),
    .key_data(key_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_hit(res_hit), .res_index(res_index), .res_action(res_action),
    .res_port(res_port), .wr_en(wr_en), .wr_index(wr_index), .wr_keep(wr_keep),
    .wr_value(wr_value), .wr_mask(wr_mask), .wr_action(wr_action), .wr_port(wr_port)
  );

  function automatic logic [KW-1:0] rnd_key();
    logic [255:0] r = {$urandom, $urandom, $urandom, $urandom,
                       $urandom, $urandom, $urandom, $urandom};
    return r[KW-1:0];
  endfunction

  // reference: lowest valid rule whose masked bits all agree
  function automatic logic [RW-1:0] ref_result(logic [KW-1:0] k);
    for (int i = 0; i < N; i++)
      if (m_ok[i] && ((k ^ m_val[i]) & m_msk[i]) == '0)
        return {1'b1, IW'(i), m_act[i], m_prt[i]};
    return {1'b0, {IW{1'b0}}, DEFA, DEFP};
  endfunction

  function automatic logic [RW-1:0] observed();
    return {res_hit, res_index, res_action, res_port};
  endfunction

  task automatic check(string tag, logic [RW-1:0] got, logic [RW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic put_rule(int i, logic keep, logic [KW-1:0] v, logic [KW-1:0] m,
                          logic [1:0] a, logic [PW-1:0] p);
    @(negedge clk);
    wr_en = 1; wr_index = IW'(i); wr_keep = keep; wr_value = v; wr_mask = m;
    wr_action = a; wr_port = p;
    m_ok[i] = keep; m_val[i] = v; m_msk[i] = m; m_act[i] = a; m_prt[i] = p;
    @(negedge clk);
    wr_en = 0;
  endtask

  // single lookup with exact latency check (R7)
  task automatic look(string tag, logic [KW-1:0] k);
    res_ready = 1;
    @(negedge clk);
    key_valid = 1; key_data = k;
    @(negedge clk);
    key_valid = 0;
    check({tag, " R7 early"}, RW'(res_valid), RW'(0));
    @(negedge clk);
    check({tag, " R7 valid"}, RW'(res_valid), RW'(1));
    check(tag, observed(), ref_result(k));
  endtask

  task automatic stream(int n, int hit_pct);
    int sent = 0, got = 0;
    logic held = 0;
    logic [RW-1:0] held_val = '0;
    while (got < n) begin
      @(negedge clk);
      res_ready = ($urandom % 4) != 0;
      #1;
      if (held && res_valid) check("R8 hold", observed(), held_val);
      held = 0;
      if (res_valid) begin
        if (res_ready) begin
          check("R4 R6 stream", observed(), expq.pop_front());
          got++;
        end else begin
          check("R8 ready low", RW'(key_ready), RW'(0));
          held = 1; held_val = observed();
        end
      end
      key_valid = 0;
      if (sent < n && key_ready) begin
        logic [KW-1:0] k = rnd_key();
        if (int'($urandom % 100) < hit_pct) begin
          int r = int'($urandom % N);
          k = (m_val[r] & m_msk[r]) | (k & ~m_msk[r]);
        end
        key_valid = 1; key_data = k;
        expq.push_back(ref_result(k));
        sent++;
      end
    end
    @(negedge clk);
    key_valid = 0; res_ready = 1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [KW-1:0] base, k;
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin
      m_ok[i] = 0; m_val[i] = '0; m_msk[i] = '0; m_act[i] = '0; m_prt[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset valid", RW'(res_valid), RW'(0));
    look("R1 R5 empty table miss", rnd_key());

    base = rnd_key();
    // rule 4: full VLAN compare [11:0], mirror to port 2
    put_rule(4, 1, base, KW'(12'hFFF), 2'd2, 3'd2);
    look("R2 R6 vlan hit", base);
    look("R2 vlan bit0 miss", base ^ KW'(1));
    look("R3 unmasked bits ignored", base ^ {16'hBEEF, {(KW-16){1'b0}}});
    // rule 2: only VLAN low 8 bits, redirect to port 6
    put_rule(2, 1, base, KW'(12'h0FF), 2'd1, 3'd6);
    look("R4 lower index wins", base);
    look("R3 partial mask", base ^ KW'(12'h200));
    // rule 7: ethertype [35:20] and protocol [19:12]
    k = rnd_key();
    put_rule(7, 1, k, {{(KW-36){1'b0}}, 16'hFFFF, 8'hFF, 12'h000}, 2'd0, 3'd1);
    look("R2 AND across fields hit", k ^ KW'(12'hABC));
    look("R2 protocol mismatch", k ^ KW'(20'h01000));
    look("R2 ethertype mismatch", k ^ {{(KW-36){1'b0}}, 16'h8000, 20'h0});
    // removal and replacement
    put_rule(2, 0, base, KW'(12'h0FF), 2'd1, 3'd6);
    look("R9 removed rule skipped", base);
    put_rule(4, 1, ~base, KW'(12'hFFF), 2'd1, 3'd3);
    look("R9 replaced rule", base);
    look("R9 new value hit", ~base);

    // random table, sparse masks, streaming with back-pressure
    for (int i = 0; i < N; i++)
      put_rule(i, ($urandom % 8) != 0, rnd_key(), rnd_key() & rnd_key() & rnd_key(),
               2'($urandom % 3), PW'($urandom));
    stream(300, 70);
    // catch-all at the last slot
    put_rule(N-1, 1, rnd_key(), '0, 2'd2, 3'd4);
    look("R3 zero mask catches all", rnd_key());
    stream(200, 30);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule